// File: doc/BRIEF.md
# Dual-port RAM with atomic test-and-set

The block is a small synchronous memory shared by two requesters. Either port can read or write any word. Either port can also issue a conditional read-modify-write, called test-and-set. A test-and-set returns the old contents of a word and a pass flag. It stores a new value only when a test chosen by the caller holds. The caller picks one of two tests: the old value equals a supplied expected value, or the old value is zero. With the zero test and a set value of 1, one bit of a word works as a spin lock. A returned 0 means the caller now owns the lock.

A granted test-and-set places its address in a reservation held by the issuing port. The reservation lasts for the accept cycle and the following cycle. A test-and-set from the other port to that address is refused with a one-cycle BUSY pulse, and the caller must retry. A plain write from the other port to that address is stalled until the reservation drops. Operations on different addresses run concurrently. Reads are never blocked.

Requests are single-cycle. A request counts as accepted in any cycle where `ready_o` for its port is high. A stalled write must be held until it is accepted. Read and test-and-set responses appear in the cycle after acceptance.

Top module: `tas_dpram`

## Requirements
- R1: Opcodes are 2'b00 read, 2'b01 write, 2'b10 test-and-set and 2'b11 no operation. An accepted write stores `wdata_i` at the end of its cycle. An accepted read gives `rvalid_o`=1 in the next cycle, with `rdata_o` equal to the word as it was in the accept cycle. Either port reaches every word. `rdata_o` is 0 whenever `rvalid_o` is 0.
- R2: A test-and-set granted in cycle C gives `rvalid_o`=1 in cycle C+1, with `rdata_o` equal to the old word. The same port has `ready_o`=0 in cycle C+1.
- R3: When `tsel_i`=0 the test passes if the old word equals `expect_i`. When `tsel_i`=1 it passes if the old word is zero. `pass_o` in cycle C+1 reports the result.
- R4: If the test passes, the word becomes the request's `wdata_i` at the end of cycle C+1. If the test fails, the word is unchanged.
- R5: A test-and-set from one port to the address held by the other port is consumed with `ready_o`=1. It gives `busy_o`=1 and `rvalid_o`=0 in the next cycle, and it does not change memory.
- R6: When both ports issue a test-and-set to the same address in the same cycle and neither holds a reservation, port 0 is granted and port 1 receives BUSY.
- R7: Test-and-set requests to different addresses in the same cycle are both granted, with no BUSY.
- R8: The owning test-and-set returns its old value and pass flag, and performs its conditional write, whether or not the other port collided with it.
- R9: A test-and-set issued by the other port after the reservation is released (in cycle C+2 or later) is granted.
- R10: The other port's write gets `ready_o`=0 and is not committed in two cases. One is a write to the address of a test-and-set granted in the same cycle. The other is a write to the address of the reservation held in cycle C+1. When both ports write the same address in one cycle, port 1's write is stalled.
- R11: A lock attempt (`tsel_i`=1, `wdata_i`=1) on a free word returns 0 with pass 1. A second attempt returns 1 with pass 0.
- R12: During and after reset, every word is 0, `ready_o` is 2'b11, and `rvalid_o`, `pass_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Request valid, one bit per port |
| op_i | input | 2x2 | Opcode per port |
| addr_i | input | 2xAW | Word address per port |
| wdata_i | input | 2xDW | Write data or test-and-set new value |
| expect_i | input | 2xDW | Expected old value for the equality test |
| tsel_i | input | 2 | Test select: 0 equal-to-expected, 1 zero |
| ready_o | output | 2 | Request accepted this cycle |
| rvalid_o | output | 2 | Read or test-and-set response valid |
| rdata_o | output | 2xDW | Read data or old value |
| pass_o | output | 2 | Test-and-set test passed |
| busy_o | output | 2 | Test-and-set refused, retry |

## Verification
The hardest state to reach is a collision in the one cycle of reservation overlap. One port's granted test-and-set must be in its second cycle while the other port targets the same word with a test-and-set or a write. Random traffic alone seldom lines this up. The stimulus therefore confines addresses to four words, so such overlaps occur often. Directed sequences add the overlap on purpose: the retry immediately after release, and a write that stalls across both reservation cycles before it commits.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_TAS = 2'b10,
    OP_NOP = 2'b11
  } op_e;

  localparam logic TSEL_EQ   = 1'b0;
  localparam logic TSEL_ZERO = 1'b1;
endpackage

// File: rtl/tas_mem.sv
module tas_mem #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 1 << AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             we_i,
  input  logic [1:0][AW-1:0]     waddr_i,
  input  logic [1:0][DW-1:0]     wdata_i,
  input  logic [1:0][AW-1:0]     raddr_i,
  output logic [1:0][DW-1:0]     rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (we_i[0]) mem_q[waddr_i[0]] <= wdata_i[0];
      if (we_i[1] && !(we_i[0] && waddr_i[0] == waddr_i[1]))
        mem_q[waddr_i[1]] <= wdata_i[1];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

  // R10: arbitration never lets both ports write one word in a cycle
  a_r10_no_double_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i[0] && we_i[1] && waddr_i[0] == waddr_i[1]));
endmodule

// File: rtl/tas_arb.sv
module tas_arb
  import tas_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic [1:0]         req_i,
  input  logic [1:0][1:0]    op_i,
  input  logic [1:0][AW-1:0] addr_i,
  input  logic [1:0]         hold_i,
  input  logic [1:0][AW-1:0] hold_addr_i,
  output logic [1:0]         ready_o,
  output logic [1:0]         grant_o,
  output logic [1:0]         refuse_o,
  output logic [1:0]         wr_go_o,
  output logic [1:0]         rd_go_o
);
  logic [1:0] tas_req, wr_req, rd_req, hit, stall;
  logic       same;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      tas_req[p] = req_i[p] && op_i[p] == OP_TAS && !hold_i[p];
      wr_req[p]  = req_i[p] && op_i[p] == OP_WR  && !hold_i[p];
      rd_req[p]  = req_i[p] && op_i[p] == OP_RD  && !hold_i[p];
      hit[p]     = hold_i[1-p] && hold_addr_i[1-p] == addr_i[p];
    end
    same = addr_i[0] == addr_i[1];
    // port 0 has priority on same-cycle contention
    refuse_o[0] = tas_req[0] && hit[0];
    grant_o[0]  = tas_req[0] && !hit[0];
    refuse_o[1] = tas_req[1] && (hit[1] || (grant_o[0] && same));
    grant_o[1]  = tas_req[1] && !refuse_o[1];
    stall[0]    = wr_req[0] && (hit[0] || (grant_o[1] && same));
    stall[1]    = wr_req[1] && (hit[1] || (grant_o[0] && same) ||
                                (wr_req[0] && !stall[0] && same));
    ready_o = ~hold_i & ~stall;
    wr_go_o = wr_req & ~stall;
    rd_go_o = rd_req;
  end
endmodule

// File: rtl/tas_port.sv
module tas_port #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] expect_i,
  input  logic          tsel_i,
  input  logic [DW-1:0] old_i,
  input  logic          grant_i,
  input  logic          refuse_i,
  input  logic          wr_go_i,
  input  logic          rd_go_i,
  output logic          hold_o,
  output logic [AW-1:0] hold_addr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          pass_o,
  output logic          busy_o
);
  logic          hold_q, pass_q, rvalid_q, busy_q, test_ok;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] set_q, rdata_q;

  assign test_ok = tsel_i ? (old_i == '0) : (old_i == expect_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      hold_addr_q <= '0;
      set_q       <= '0;
      pass_q      <= 1'b0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
      busy_q      <= 1'b0;
    end else begin
      hold_q   <= grant_i;
      pass_q   <= grant_i && test_ok;
      rvalid_q <= grant_i || rd_go_i;
      rdata_q  <= (grant_i || rd_go_i) ? old_i : '0;
      busy_q   <= refuse_i;
      if (grant_i) begin
        hold_addr_q <= addr_i;
        set_q       <= wdata_i;
      end
    end
  end

  assign hold_o      = hold_q;
  assign hold_addr_o = hold_addr_q;
  assign we_o        = (hold_q && pass_q) || wr_go_i;
  assign waddr_o     = hold_q ? hold_addr_q : addr_i;
  assign wdata_o     = hold_q ? set_q : wdata_i;
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign pass_o      = pass_q;
  assign busy_o      = busy_q;

  a_r2_hold_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> !hold_q);
  a_r5_busy_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !rvalid_q);
  a_r3_pass_only_tas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q |-> (hold_q && rvalid_q));
  a_r4_fail_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !pass_q) |-> !we_o);
endmodule

// File: rtl/tas_dpram.sv
module tas_dpram
  import tas_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         req_i,
  input  logic [1:0][1:0]    op_i,
  input  logic [1:0][AW-1:0] addr_i,
  input  logic [1:0][DW-1:0] wdata_i,
  input  logic [1:0][DW-1:0] expect_i,
  input  logic [1:0]         tsel_i,
  output logic [1:0]         ready_o,
  output logic [1:0]         rvalid_o,
  output logic [1:0][DW-1:0] rdata_o,
  output logic [1:0]         pass_o,
  output logic [1:0]         busy_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [1:0]         hold, grant, refuse, wr_go, rd_go, we;
  logic [1:0][AW-1:0] hold_addr, waddr;
  logic [1:0][DW-1:0] wdat, rd_word;

  tas_arb #(.AW(AW)) i_arb (
    .req_i, .op_i, .addr_i,
    .hold_i(hold), .hold_addr_i(hold_addr),
    .ready_o, .grant_o(grant), .refuse_o(refuse),
    .wr_go_o(wr_go), .rd_go_o(rd_go)
  );

  tas_mem #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_mem (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdat),
    .raddr_i(addr_i), .rdata_o(rd_word)
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    tas_port #(.AW(AW), .DW(DW)) i_port (
      .clk_i, .rst_ni,
      .addr_i(addr_i[p]), .wdata_i(wdata_i[p]), .expect_i(expect_i[p]),
      .tsel_i(tsel_i[p]), .old_i(rd_word[p]),
      .grant_i(grant[p]), .refuse_i(refuse[p]),
      .wr_go_i(wr_go[p]), .rd_go_i(rd_go[p]),
      .hold_o(hold[p]), .hold_addr_o(hold_addr[p]),
      .we_o(we[p]), .waddr_o(waddr[p]), .wdata_o(wdat[p]),
      .rvalid_o(rvalid_o[p]), .rdata_o(rdata_o[p]),
      .pass_o(pass_o[p]), .busy_o(busy_o[p])
    );

    // R10: the other port never writes into a held word
    a_r10_hold_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold[p] && we[1-p]) |-> waddr[1-p] != hold_addr[p]);
  end

  a_r5_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold[0] && hold[1]) |-> hold_addr[0] != hold_addr[1]);

  a_r6_port0_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && op_i[0] == OP_TAS && op_i[1] == OP_TAS &&
     addr_i[0] == addr_i[1] && hold == 2'b00) |=> (rvalid_o[0] && busy_o[1]));

  a_r7_disjoint_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && op_i[0] == OP_TAS && op_i[1] == OP_TAS &&
     addr_i[0] != addr_i[1] && hold == 2'b00) |=> (busy_o == 2'b00 && rvalid_o == 2'b11));
endmodule

// File: tb/test_tas_dpram.sv
module test_tas_dpram;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]         req;
  logic [1:0][1:0]    op;
  logic [1:0][AW-1:0] addr;
  logic [1:0][DW-1:0] wd, ex;
  logic [1:0]         ts;
  logic [1:0]         ready, rvalid, pass, busy;
  logic [1:0][DW-1:0] rdata;

  tas_dpram #(.AW(AW), .DW(DW)) i_tas_dpram (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wd), .expect_i(ex), .tsel_i(ts), .ready_o(ready),
    .rvalid_o(rvalid), .rdata_o(rdata), .pass_o(pass), .busy_o(busy)
  );

  logic [DW-1:0]      mm [DEPTH];
  logic [1:0]         ph, psm, last_rdy;
  logic [1:0][AW-1:0] ra;
  logic [1:0][DW-1:0] nv;
  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic test_ok(logic [DW-1:0] old, logic [DW-1:0] e, logic t);
    return t ? (old == '0) : (old == e);
  endfunction

  task automatic set(int p, logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] w,
                     logic [DW-1:0] e, logic t);
    req[p] = 1'b1; op[p] = o; addr[p] = a; wd[p] = w; ex[p] = e; ts[p] = t;
  endtask

  task automatic idle();
    req = '0;
  endtask

  // one cycle: model the cycle, check ready, then the registered responses
  task automatic cyc();
    logic [1:0] tgo, wr, rd, hit, cf, g, st, er, eps;
    logic [1:0][DW-1:0] erd;
    #1;
    for (int p = 0; p < 2; p++) begin
      tgo[p] = req[p] && op[p] == 2'b10 && !ph[p];
      wr[p]  = req[p] && op[p] == 2'b01 && !ph[p];
      rd[p]  = req[p] && op[p] == 2'b00 && !ph[p];
      hit[p] = ph[1-p] && ra[1-p] == addr[p];
    end
    cf[0] = tgo[0] && hit[0];
    g[0]  = tgo[0] && !cf[0];
    cf[1] = tgo[1] && (hit[1] || (g[0] && addr[0] == addr[1]));
    g[1]  = tgo[1] && !cf[1];
    st[0] = wr[0] && (hit[0] || (g[1] && addr[1] == addr[0]));
    st[1] = wr[1] && (hit[1] || (g[0] && addr[0] == addr[1]) ||
                      (wr[0] && !st[0] && addr[0] == addr[1]));
    er = ~ph & ~st;
    chk("R10", "ready", {30'd0, ready}, {30'd0, er});
    last_rdy = ready;
    for (int p = 0; p < 2; p++) begin
      erd[p] = (rd[p] || g[p]) ? mm[addr[p]] : '0;
      eps[p] = g[p] && test_ok(mm[addr[p]], ex[p], ts[p]);
    end
    for (int p = 0; p < 2; p++) if (ph[p] && psm[p]) mm[ra[p]] = nv[p];
    for (int p = 0; p < 2; p++) if (wr[p] && !st[p]) mm[addr[p]] = wd[p];
    for (int p = 0; p < 2; p++) begin
      ph[p] = g[p];
      psm[p] = eps[p];
      if (g[p]) begin ra[p] = addr[p]; nv[p] = wd[p]; end
    end
    @(posedge clk); #1;
    for (int p = 0; p < 2; p++) begin
      chk("R2", "rvalid", {31'd0, rvalid[p]}, {31'd0, rd[p] || g[p]});
      chk("R1", "rdata", {24'd0, rdata[p]}, {24'd0, erd[p]});
      chk("R3", "pass", {31'd0, pass[p]}, {31'd0, eps[p]});
      chk("R5", "busy", {31'd0, busy[p]}, {31'd0, cf[p]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    req = '0; op = '0; addr = '0; wd = '0; ex = '0; ts = '0;
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    ph = '0; psm = '0; ra = '0; nv = '0; last_rdy = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "ready in reset", {30'd0, ready}, 32'd3);
    chk("R12", "rvalid in reset", {30'd0, rvalid}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R12", "pass/busy after reset", {28'd0, pass, busy}, 32'd0);
    set(0, 2'b00, 4'd9, 0, 0, 0); cyc();
    chk("R12", "word after reset", {24'd0, rdata[0]}, 32'd0);

    // R1: cross-port write/read, no-op code
    idle(); set(0, 2'b01, 4'd5, 8'hA5, 0, 0); set(1, 2'b01, 4'd6, 8'h3C, 0, 0); cyc();
    idle(); set(1, 2'b00, 4'd5, 0, 0, 0); set(0, 2'b00, 4'd6, 0, 0, 0); cyc();
    chk("R1", "port1 reads port0 write", {24'd0, rdata[1]}, 32'hA5);
    chk("R1", "port0 reads port1 write", {24'd0, rdata[0]}, 32'h3C);
    idle(); set(0, 2'b11, 4'd5, 0, 0, 0); cyc();
    chk("R1", "no-op no response", {31'd0, rvalid[0]}, 32'd0);

    // R11: lock idiom
    idle(); set(0, 2'b10, 4'd2, 8'd1, 0, 1'b1); cyc();
    chk("R11", "first lock old", {24'd0, rdata[0]}, 32'd0);
    chk("R11", "first lock pass", {31'd0, pass[0]}, 32'd1);
    chk("R2", "ready low in second cycle", {31'd0, ready[0]}, 32'd0);
    idle(); cyc();
    idle(); set(0, 2'b10, 4'd2, 8'd1, 0, 1'b1); cyc();
    chk("R11", "second lock old", {24'd0, rdata[0]}, 32'd1);
    chk("R11", "second lock pass", {31'd0, pass[0]}, 32'd0);

    // R5, R8, R9: collision while held, then retry
    idle(); cyc();
    idle(); set(0, 2'b10, 4'd3, 8'd7, 8'd0, 1'b0); cyc();
    chk("R8", "owner old", {24'd0, rdata[0]}, 32'd0);
    idle(); set(1, 2'b10, 4'd3, 8'd9, 8'd0, 1'b0); cyc();
    chk("R5", "consumed", {31'd0, last_rdy[1]}, 32'd1);
    chk("R5", "collider busy", {31'd0, busy[1]}, 32'd1);
    idle(); set(1, 2'b10, 4'd3, 8'd9, 8'd7, 1'b0); cyc();
    chk("R9", "retry granted", {31'd0, rvalid[1]}, 32'd1);
    chk("R8", "owner write visible", {24'd0, rdata[1]}, 32'd7);
    idle(); cyc();
    idle(); set(0, 2'b00, 4'd3, 0, 0, 0); cyc();
    chk("R4", "retry write", {24'd0, rdata[0]}, 32'd9);

    // R6 and R7
    idle(); set(0, 2'b10, 4'd4, 8'h11, 0, 1'b1); set(1, 2'b10, 4'd4, 8'h22, 0, 1'b1); cyc();
    chk("R6", "port0 granted", {31'd0, rvalid[0]}, 32'd1);
    chk("R6", "port1 busy", {31'd0, busy[1]}, 32'd1);
    idle(); cyc();
    idle(); set(0, 2'b10, 4'd7, 8'h44, 0, 1'b1); set(1, 2'b10, 4'd8, 8'h55, 0, 1'b1); cyc();
    chk("R7", "both valid", {30'd0, rvalid}, 32'd3);
    chk("R7", "no busy", {30'd0, busy}, 32'd0);
    idle(); cyc();

    // R3, R4: equality test failure leaves word unchanged
    idle(); set(1, 2'b10, 4'd7, 8'h99, 8'h00, 1'b0); cyc();
    chk("R3", "mismatch fails", {31'd0, pass[1]}, 32'd0);
    idle(); cyc();
    idle(); set(1, 2'b00, 4'd7, 0, 0, 0); cyc();
    chk("R4", "unchanged", {24'd0, rdata[1]}, 32'h44);

    // R10: write stalls across the reservation, then commits
    idle(); set(0, 2'b10, 4'd6, 8'h77, 8'h3C, 1'b0); set(1, 2'b01, 4'd6, 8'hEE, 0, 0); cyc();
    chk("R10", "stall in grant cycle", {31'd0, last_rdy[1]}, 32'd0);
    req[0] = 1'b0; cyc();
    chk("R10", "stall in hold cycle", {31'd0, last_rdy[1]}, 32'd0);
    cyc();
    chk("R10", "write accepted", {31'd0, last_rdy[1]}, 32'd1);
    idle(); set(0, 2'b00, 4'd6, 0, 0, 0); cyc();
    chk("R10", "late write wins", {24'd0, rdata[0]}, 32'hEE);
    idle(); set(0, 2'b01, 4'd1, 8'h01, 0, 0); set(1, 2'b01, 4'd1, 8'h02, 0, 0); cyc();
    chk("R10", "same-word port1 stalls", {30'd0, last_rdy}, 32'd1);
    idle(); cyc();

    // random traffic on a few words
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++) begin
        req[p]  = ($urandom % 4) != 0;
        op[p]   = 2'($urandom % 4);
        addr[p] = AW'($urandom % 4);
        wd[p]   = DW'($urandom);
        ex[p]   = ($urandom % 2) ? DW'($urandom) : mm[addr[p]];
        ts[p]   = 1'($urandom % 2);
      end
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule